// File: doc/BRIEF.md
# Fieldbus Bit-Time Timer Unit

This block supplies the protocol timers that a fieldbus MAC needs, such as the minimum delay before a station answers a request. Every timer is programmed as a number of bit times. The block does not re-clock itself for each line rate. A single prescaler divides the core clock down to a fixed 12 MHz tick, so one tick is one bit time at the fastest rate. Each timer then counts the requested number of bits multiplied by a rate-dependent scaling factor. One prescaler setting therefore covers every supported rate, from 12 Mbaud down to 9.6 kbaud. The prescaler alone could not reach the slow rates, because its divide code is only 10 bits wide.

The MAC selects the line rate with a 4-bit code. Each timer channel has a start strobe, a 16-bit bit count and a cancel strobe. Each channel reports a busy flag and a one-cycle expiry pulse. The parameter `NUM_CH` sets the number of channels, and the default is two. The rate code is sampled on the start cycle. Changing the rate code afterwards does not affect a timer that is already running. Codes that do not name a rate fall back to a factor of 1 and raise `config_error`.

Top module: `fbus_bit_timer`

## Requirements
- R1: The prescaler emits one tick every `PRESCALE_CODE + 2` core cycles. The stored code is two less than the divide value. Codes 30, 14 and 22 give a 12 MHz tick from 384, 192 and 288 MHz.
- R2: `baud_sel` selects the scaling factor. Code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8, code 4 gives 24, code 5 gives 64, code 6 gives 128, code 7 gives 264, code 8 gives 625 and code 9 gives 1250. These codes stand for 12M, 6M, 3M, 1.5M, 500k, 187.5k, 93.75k, 45.45k, 19.2k and 9.6k baud.
- R3: A nonzero timer expires after exactly N = bits × factor ticks. Take the start edge as edge 0. The expiry pulse is then visible after edge k, with (N−1)·D+1 ≤ k ≤ N·D, where D is the divide value. For example, 11 bits at code 3 gives 88 ticks.
- R4: Codes 10 to 15 behave as factor 1. `config_error` is high in the cycle after such a code is applied. It is low in the cycle after a code from 0 to 9 is applied.
- R5: After a start with a nonzero product, `tmr_busy` is high from the next cycle until expiry. `tmr_expire` is high for exactly one cycle, and `tmr_busy` is low in that same cycle.
- R6: A start with a bit count of 0 gives an expiry pulse in the cycle after the start, and `tmr_busy` stays low.
- R7: A start on a channel that is already running reloads that channel. The new duration is measured from the new start.
- R8: A cancel clears the channel in the next cycle, and no expiry pulse follows. If cancel and start arrive in the same cycle, cancel wins.
- R9: The channels run independently. Each channel's timing is unaffected by the activity of the others.
- R10: The factor is captured at start. Changing `baud_sel` while a timer runs does not change its duration.
- R11: In reset, all busy flags, all expiry pulses and `config_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_sel | input | 4 | Line-rate code |
| tmr_start | input | NUM_CH | Per-channel start or reload strobe |
| tmr_bits | input | NUM_CH*BITS_W | Per-channel bit count; channel i is in bits [i*BITS_W +: BITS_W] |
| tmr_cancel | input | NUM_CH | Per-channel cancel strobe |
| tmr_expire | output | NUM_CH | One-cycle expiry pulse |
| tmr_busy | output | NUM_CH | Channel running |
| config_error | output | 1 | Unused rate code applied |

## Verification
The bench builds the block with `PRESCALE_CODE = 0`, which gives a tick every second core cycle. It keeps the defaults of two channels and 16-bit counts. The short tick lets the bench apply all sixteen rate codes, including the 9.6 kbaud factor of 1250, with several bit counts each. Every latency is checked against the tick window computed from bits × factor. The bench also covers the 11-bit response case, reload, cancel, zero count, rate change during a run, and two channels running concurrently.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
    // Width of the scaling factor (largest factor 1250 fits in 11 bits)
    localparam int unsigned FACT_W = 11;
    // Width of the rate-select code
    localparam int unsigned SEL_W  = 4;
    // Width of the prescaler divide code
    localparam int unsigned PS_W   = 10;
    // Number of defined rate codes
    localparam int unsigned NUM_RATES = 10;

    // Scaling factor for a rate code; unknown codes map to 1
    function automatic logic [FACT_W-1:0] factor_of(input logic [SEL_W-1:0] code);
        logic [FACT_W-1:0] f;
        unique case (code)
            4'd0:    f = FACT_W'(1);
            4'd1:    f = FACT_W'(2);
            4'd2:    f = FACT_W'(4);
            4'd3:    f = FACT_W'(8);
            4'd4:    f = FACT_W'(24);
            4'd5:    f = FACT_W'(64);
            4'd6:    f = FACT_W'(128);
            4'd7:    f = FACT_W'(264);
            4'd8:    f = FACT_W'(625);
            4'd9:    f = FACT_W'(1250);
            default: f = FACT_W'(1);
        endcase
        return f;
    endfunction
endpackage

// File: rtl/fbt_prescaler.sv
module fbt_prescaler #(
    parameter int unsigned PRESCALE_CODE = 30
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV  = PRESCALE_CODE + 2;
    localparam int unsigned CW   = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_state_t;

    ps_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick = (s_q.cnt == LAST);
endmodule

// File: rtl/fbt_scale_lut.sv
module fbt_scale_lut
    import fbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  baud_sel,
    output logic [FACT_W-1:0] factor,
    output logic              cfg_err
);
    typedef struct packed {
        logic err;
    } lut_state_t;

    lut_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = (32'(baud_sel) >= NUM_RATES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Factor is used combinationally at the start strobe; error flag is registered
    assign factor  = factor_of(baud_sel);
    assign cfg_err = s_q.err;
endmodule

// File: rtl/fbt_channel.sv
module fbt_channel
    import fbt_pkg::*;
#(
    parameter int unsigned BITS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              cancel,
    input  logic [BITS_W-1:0] bits,
    input  logic [FACT_W-1:0] factor,
    output logic              expire,
    output logic              busy
);
    localparam int unsigned CNT_W = BITS_W + FACT_W;

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             busy;
        logic             expire;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic [CNT_W-1:0] product;

    assign product = CNT_W'(bits) * CNT_W'(factor);

    always_comb begin
        s_d        = s_q;
        s_d.expire = 1'b0;
        if (cancel) begin
            s_d.rem  = '0;
            s_d.busy = 1'b0;
        end else if (start) begin
            if (product == '0) begin
                s_d.rem    = '0;
                s_d.busy   = 1'b0;
                s_d.expire = 1'b1;
            end else begin
                s_d.rem  = product;
                s_d.busy = 1'b1;
            end
        end else if (s_q.busy && tick) begin
            if (s_q.rem == CNT_W'(1)) begin
                s_d.rem    = '0;
                s_d.busy   = 1'b0;
                s_d.expire = 1'b1;
            end else begin
                s_d.rem = s_q.rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign expire = s_q.expire;
    assign busy   = s_q.busy;
endmodule

// File: rtl/fbus_bit_timer.sv
module fbus_bit_timer
    import fbt_pkg::*;
#(
    parameter int unsigned NUM_CH        = 2,
    parameter int unsigned BITS_W        = 16,
    parameter int unsigned PRESCALE_CODE = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         baud_sel,
    input  logic [NUM_CH-1:0]        tmr_start,
    input  logic [NUM_CH*BITS_W-1:0] tmr_bits,
    input  logic [NUM_CH-1:0]        tmr_cancel,
    output logic [NUM_CH-1:0]        tmr_expire,
    output logic [NUM_CH-1:0]        tmr_busy,
    output logic                     config_error
);
    logic              tick_w;
    logic [FACT_W-1:0] factor_w;

    fbt_prescaler #(
        .PRESCALE_CODE(PRESCALE_CODE)
    ) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    fbt_scale_lut u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud_sel(baud_sel),
        .factor  (factor_w),
        .cfg_err (config_error)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        fbt_channel #(
            .BITS_W(BITS_W)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_w),
            .start (tmr_start[i]),
            .cancel(tmr_cancel[i]),
            .bits  (tmr_bits[i*BITS_W +: BITS_W]),
            .factor(factor_w),
            .expire(tmr_expire[i]),
            .busy  (tmr_busy[i])
        );
    end
endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned BITS_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic [NUM_CH-1:0]        tmr_start,
    input logic [NUM_CH*BITS_W-1:0] tmr_bits,
    input logic [NUM_CH-1:0]        tmr_cancel,
    input logic [NUM_CH-1:0]        tmr_expire,
    input logic [NUM_CH-1:0]        tmr_busy
);
    // R1: divide value is at least two, so ticks never come back to back
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_expire_drops_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_expire[i] |-> !tmr_busy[i]);

        assert_expire_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_expire[i] |-> ($past(tmr_busy[i]) || $past(tmr_start[i])));

        assert_start_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_start[i] && !tmr_cancel[i] && (tmr_bits[i*BITS_W +: BITS_W] != '0))
            |=> tmr_busy[i]);

        assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_start[i] && !tmr_cancel[i] && (tmr_bits[i*BITS_W +: BITS_W] == '0))
            |=> (tmr_expire[i] && !tmr_busy[i]));

        assert_cancel_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_cancel[i] |=> (!tmr_busy[i] && !tmr_expire[i]));
    end
endmodule

bind fbus_bit_timer fbt_checker #(
    .NUM_CH(NUM_CH),
    .BITS_W(BITS_W)
) u_fbt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .tmr_start (tmr_start),
    .tmr_bits  (tmr_bits),
    .tmr_cancel(tmr_cancel),
    .tmr_expire(tmr_expire),
    .tmr_busy  (tmr_busy)
);

// File: tb/test_fbus_bit_timer.sv
module test_fbus_bit_timer;
    localparam int NCH = 2;
    localparam int BW  = 16;
    localparam int PSC = 0;
    localparam int DIV = PSC + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      baud_sel = '0;
    logic [NCH-1:0]  tmr_start = '0;
    logic [NCH*BW-1:0] tmr_bits = '0;
    logic [NCH-1:0]  tmr_cancel = '0;
    logic [NCH-1:0]  tmr_expire;
    logic [NCH-1:0]  tmr_busy;
    logic            config_error;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    fbus_bit_timer #(.NUM_CH(NCH), .BITS_W(BW), .PRESCALE_CODE(PSC)) i_fbus_bit_timer (
        .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .tmr_start(tmr_start),
        .tmr_bits(tmr_bits), .tmr_cancel(tmr_cancel), .tmr_expire(tmr_expire),
        .tmr_busy(tmr_busy), .config_error(config_error));

    function automatic int fac(input int code);
        case (code)
            0: return 1;    1: return 2;    2: return 4;    3: return 8;
            4: return 24;   5: return 64;   6: return 128;  7: return 264;
            8: return 625;  9: return 1250; default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic chk_window(input string req, input int lat, input int n);
        int lo = (n - 1) * DIV + 1;
        int hi = n * DIV;
        chk(lat >= lo && lat <= hi, req, lat, hi);
    endtask

    // Pulse start at a negedge; returns at the negedge after the start edge
    task automatic arm(input int ch, input int b);
        tmr_bits[ch*BW +: BW] = BW'(b);
        tmr_start[ch] = 1'b1;
        @(negedge clk);
        tmr_start[ch] = 1'b0;
    endtask

    task automatic wait_exp(input int ch, input int limit, output int lat);
        lat = 0;
        while (!tmr_expire[ch] && lat < limit) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_one(input int ch, input int code, input int b, input string req);
        int lat;
        int n = b * fac(code);
        baud_sel = 4'(code);
        @(negedge clk);
        arm(ch, b);
        chk(tmr_busy[ch] == 1'b1, {req, " busy after start (R5)"}, int'(tmr_busy[ch]), 1);
        wait_exp(ch, n * DIV + 20, lat);
        chk_window(req, lat, n);
        chk(tmr_busy[ch] == 1'b0, "R5 busy low with expiry", int'(tmr_busy[ch]), 0);
        @(negedge clk);
        chk(tmr_expire[ch] == 1'b0, "R5 expiry one cycle", int'(tmr_expire[ch]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int lat;
        int lat1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(tmr_busy == '0, "R11 busy in reset", int'(tmr_busy), 0);
        chk(tmr_expire == '0, "R11 expire in reset", int'(tmr_expire), 0);
        chk(config_error == 1'b0, "R11 config_error in reset", int'(config_error), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 config_error over all codes
        for (int c = 0; c < 16; c++) begin
            baud_sel = 4'(c);
            @(negedge clk);
            chk(config_error == (c >= 10), "R4 config_error", int'(config_error), int'(c >= 10));
        end

        // R2/R3/R4 sweep over all codes and small bit counts
        for (int c = 0; c < 16; c++) begin
            for (int b = 1; b <= 3; b++) begin
                run_one(c % NCH, c, b, (c >= 10) ? "R4 fallback factor" : "R2 R3 factor sweep");
            end
        end

        // R3 one-character response delay at 1.5 Mbaud: 88 ticks; R1 spacing
        run_one(0, 3, 11, "R3 eleven bits");
        run_one(1, 0, 40, "R1 tick period");

        // R6 zero count
        baud_sel = 4'd5;
        @(negedge clk);
        arm(0, 0);
        chk(tmr_expire[0] == 1'b1, "R6 zero-count expiry", int'(tmr_expire[0]), 1);
        chk(tmr_busy[0] == 1'b0, "R6 zero-count busy", int'(tmr_busy[0]), 0);

        // R7 reload while running
        baud_sel = 4'd0;
        @(negedge clk);
        arm(0, 20);
        repeat (15) @(negedge clk);
        chk(tmr_expire[0] == 1'b0, "R7 no early expiry", int'(tmr_expire[0]), 0);
        arm(0, 20);
        wait_exp(0, 100, lat);
        chk_window("R7 reload duration", lat, 20);

        // R8 cancel
        arm(1, 30);
        repeat (5) @(negedge clk);
        tmr_cancel[1] = 1'b1;
        @(negedge clk);
        tmr_cancel[1] = 1'b0;
        chk(tmr_busy[1] == 1'b0, "R8 busy after cancel", int'(tmr_busy[1]), 1'b0);
        wait_exp(1, 80, lat);
        chk(lat == 80, "R8 no expiry after cancel", lat, 80);

        // R8 cancel wins over simultaneous start
        tmr_bits[BW +: BW] = BW'(5);
        tmr_start[1] = 1'b1;
        tmr_cancel[1] = 1'b1;
        @(negedge clk);
        tmr_start[1] = 1'b0;
        tmr_cancel[1] = 1'b0;
        chk(tmr_busy[1] == 1'b0, "R8 cancel priority", int'(tmr_busy[1]), 0);
        wait_exp(1, 20, lat);
        chk(lat == 20, "R8 no expiry on cancel priority", lat, 20);

        // R10 rate change during a run
        baud_sel = 4'd9;
        @(negedge clk);
        arm(0, 1);
        baud_sel = 4'd0;
        wait_exp(0, 1250 * DIV + 20, lat);
        chk_window("R10 factor captured at start", lat, 1250);

        // R9 two channels concurrently: ch0 192 ticks, ch1 64 ticks
        baud_sel = 4'd5;
        @(negedge clk);
        tmr_bits = {BW'(1), BW'(3)};
        tmr_start = 2'b11;
        @(negedge clk);
        tmr_start = 2'b00;
        lat = 0;
        while (!tmr_expire[1] && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk_window("R9 channel 1 duration", lat, 64);
        chk(tmr_busy[0] == 1'b1, "R9 channel 0 still running", int'(tmr_busy[0]), 1);
        lat1 = lat;
        while (!tmr_expire[0] && lat1 < 500) begin
            @(negedge clk);
            lat1++;
        end
        chk_window("R9 channel 0 duration", lat1, 192);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule